// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block is the status register of an I2C controller. The transfer engine sends it single-cycle event strobes. The block holds each strobe as a sticky flag until software clears it. The flags are: transmit buffer emptied, transmit finished, receive buffer filled, acknowledge missing, stop condition seen, and arbitration lost. Two of the flags have gated set conditions:
- The transmit-finished flag sets on the rising edge of the ninth SCL clock, but only while the transmit-empty flag is already held.
- The missing-acknowledge flag sets only while acknowledge checking is enabled.

Software reads the register over a simple one-cycle read/write port. A flag clears only through a handshake: software must first read the flag as 1 and then write 0 to that bit. A write of 0 without that earlier read leaves the flag unchanged, and so does a write of 1. The block drives one interrupt request. It is the OR of the flags, each masked by its own enable input.

Top module: `i2c_status_flags`

## Requirements
- R1: Synchronous active-high reset clears all six flags and all read latches. After reset, `reg_rdata` is 0x00 and `irq` is 0.
- R2: `reg_rdata` shows the flags in a fixed layout: bit 7 transmit-empty, bit 6 transmit-end, bit 5 receive-full, bit 4 no-ack, bit 3 stop-seen, bit 2 arbitration-lost. Bits 1 and 0 always read 0.
- R3: A strobe on `ev_tx_empty`, `ev_rx_full`, `ev_stop` or `ev_arb_lost` sets its flag at that clock edge. Every flag stays at 1 through any cycle without a register write.
- R4: The transmit-end flag sets on `scl_ninth_rise` only if the transmit-empty flag was already 1 before that edge.
- R5: The no-ack flag sets on `ev_nack` only while `ack_chk_en` is 1.
- R6: A write with bit k equal to 0 clears flag k if a read returned 1 in bit k after the previous write.
- R7: A write of 0 to a bit that was not read as 1 since the previous write leaves that flag set. Every write disarms all read latches.
- R8: Writing 1 to a flag bit has no effect. Writes to bits 1 and 0 are ignored.
- R9: If a set event and a valid clearing write hit the same flag in the same cycle, the flag stays 1.
- R10: `irq` is 1 exactly when some flag is 1 and its enable is also 1. `irq_en` bit k masks the flag shown at `reg_rdata` bit k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_empty | input | 1 | Transmit holding byte moved to the shifter |
| ev_rx_full | input | 1 | Received byte moved to the data register |
| ev_nack | input | 1 | No acknowledge seen during transmission |
| ev_stop | input | 1 | Stop condition seen after a frame |
| ev_arb_lost | input | 1 | Arbitration lost in master mode |
| scl_ninth_rise | input | 1 | Rising edge of the ninth SCL clock |
| ack_chk_en | input | 1 | Acknowledge-check enable |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (current flags) |
| irq_en | input | 6 | Per-flag interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The case of interest is a set event and a valid clearing write landing on the same flag in one clock. The bench provokes it two ways:
- Directed: it arms the receive-full bit by reading it, then writes 0 while `ev_rx_full` pulses in that same cycle. The flag must read back as 1.
- Random: reads, writes and strobes are drawn independently, so set and clear collide on every flag many times.

A bench model decides the expected register value each cycle and resolves every collision in favour of the set.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int NFLAG    = 6;
    localparam int REG_W    = 8;
    localparam int FLAG_LSB = REG_W - NFLAG;

    // position of each flag inside the flag vector (register bit = index + FLAG_LSB)
    typedef enum int {
        F_ARB   = 0,
        F_STOP  = 1,
        F_NACK  = 2,
        F_RXF   = 3,
        F_TXEND = 4,
        F_TXE   = 5
    } flag_idx_e;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic txe;
        logic rxf;
        logic nack;
        logic stop;
        logic arb;
    } evt_t;

    function automatic logic [REG_W-1:0] place_flags(flag_vec_t f);
        return REG_W'(f) << FLAG_LSB;
    endfunction

    function automatic flag_vec_t pick_flags(logic [REG_W-1:0] r);
        return r[REG_W-1:FLAG_LSB];
    endfunction
endpackage

// File: rtl/stat_set_qual.sv
module stat_set_qual
    import i2c_stat_pkg::*;
(
    input  evt_t      evt,
    input  logic      scl_ninth_rise,
    input  logic      ack_chk_en,
    input  logic      txe_held,
    output flag_vec_t set_vec
);
    always_comb begin
        set_vec          = '0;
        set_vec[F_TXE]   = evt.txe;
        set_vec[F_TXEND] = scl_ninth_rise & txe_held;
        set_vec[F_RXF]   = evt.rxf;
        set_vec[F_NACK]  = evt.nack & ack_chk_en;
        set_vec[F_STOP]  = evt.stop;
        set_vec[F_ARB]   = evt.arb;
    end
endmodule

// File: rtl/stat_flag_cell.sv
module stat_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic rd,
    input  logic wr,
    input  logic wr_bit,
    output logic flag
);
    logic armed;
    logic clr_ok;

    assign clr_ok = wr & ~wr_bit & armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (set_ev)
                flag <= 1'b1;
            else if (clr_ok)
                flag <= 1'b0;
            armed <= (wr ? 1'b0 : armed) | (rd & flag);
        end
    end
endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge
    import i2c_stat_pkg::*;
(
    input  flag_vec_t flags,
    input  flag_vec_t en,
    output logic      irq
);
    assign irq = |(flags & en);
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_tx_empty,
    input  logic                 ev_rx_full,
    input  logic                 ev_nack,
    input  logic                 ev_stop,
    input  logic                 ev_arb_lost,
    input  logic                 scl_ninth_rise,
    input  logic                 ack_chk_en,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NFLAG-1:0]     irq_en,
    output logic                 irq
);
    evt_t      evt;
    flag_vec_t set_vec;
    flag_vec_t flags;
    flag_vec_t wbits;

    assign evt   = '{txe: ev_tx_empty, rxf: ev_rx_full, nack: ev_nack,
                     stop: ev_stop, arb: ev_arb_lost};
    assign wbits = pick_flags(reg_wdata);

    stat_set_qual u_qual (
        .evt            (evt),
        .scl_ninth_rise (scl_ninth_rise),
        .ack_chk_en     (ack_chk_en),
        .txe_held       (flags[F_TXE]),
        .set_vec        (set_vec)
    );

    for (genvar k = 0; k < NFLAG; k++) begin : g_cell
        stat_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_ev (set_vec[k]),
            .rd     (reg_rd),
            .wr     (reg_wr),
            .wr_bit (wbits[k]),
            .flag   (flags[k])
        );
    end

    assign reg_rdata = place_flags(flags);

    stat_irq_merge u_irq (
        .flags (flags),
        .en    (irq_en),
        .irq   (irq)
    );
endmodule

// File: rtl/i2c_status_flags_chk.sv
module i2c_status_flags_chk
    import i2c_stat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ev_tx_empty,
    input logic             ev_nack,
    input logic             scl_ninth_rise,
    input logic             ack_chk_en,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [NFLAG-1:0] irq_en,
    input logic             irq
);
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[FLAG_LSB-1:0] == '0);

    a_r4_tend_gated: assert property (@(posedge clk) disable iff (rst)
        (scl_ninth_rise && !reg_rdata[7] && !reg_rdata[6]) |=> !reg_rdata[6]);

    a_r5_nack_gated: assert property (@(posedge clk) disable iff (rst)
        (!ack_chk_en && !reg_rdata[4]) |=> !reg_rdata[4]);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_tx_empty |=> reg_rdata[7]);

    a_r5_nack_sets: assert property (@(posedge clk) disable iff (rst)
        (ev_nack && ack_chk_en) |=> reg_rdata[4]);

    a_r10_irq_mask: assert property (@(posedge clk) disable iff (rst)
        irq == |(reg_rdata[REG_W-1:FLAG_LSB] & irq_en));

    for (genvar k = FLAG_LSB; k < REG_W; k++) begin : g_bit
        a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
            (!reg_wr && reg_rdata[k]) |=> reg_rdata[k]);
        a_r8_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_wdata[k] && reg_rdata[k]) |=> reg_rdata[k]);
    end
endmodule

bind i2c_status_flags i2c_status_flags_chk u_chk (.*);

// File: tb/tb_i2c_status_flags.sv
module tb_i2c_status_flags;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_tx_empty = 0, ev_rx_full = 0, ev_nack = 0, ev_stop = 0, ev_arb_lost = 0;
    logic       scl_ninth_rise = 0, ack_chk_en = 0, reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [5:0] irq_en = 6'h00;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model: index 5 tx-empty .. 0 arb-lost, register bit = index + 2
    logic [5:0] mf   = '0;
    logic [5:0] marm = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_status_flags dut (
        .clk(clk), .rst(rst),
        .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full), .ev_nack(ev_nack),
        .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
        .scl_ninth_rise(scl_ninth_rise), .ack_chk_en(ack_chk_en),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [5:0] set_of(logic [5:0] f);
        logic [5:0] s;
        s[5] = ev_tx_empty;
        s[4] = scl_ninth_rise & f[5];
        s[3] = ev_rx_full;
        s[2] = ev_nack & ack_chk_en;
        s[1] = ev_stop;
        s[0] = ev_arb_lost;
        return s;
    endfunction

    task automatic model_step();
        logic [5:0] s, clr, na;
        if (rst) begin
            mf = '0; marm = '0;
        end else begin
            s   = set_of(mf);
            clr = reg_wr ? (~reg_wdata[7:2] & marm) : 6'h00;
            na  = (reg_wr ? 6'h00 : marm) | (reg_rd ? mf : 6'h00);
            mf  = s | (mf & ~clr);
            marm = na;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ev_tx_empty = 0; ev_rx_full = 0; ev_nack = 0; ev_stop = 0; ev_arb_lost = 0;
        scl_ninth_rise = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 8'h00;
    endtask

    task automatic chk(string tag);
        logic [7:0] exp_r;
        logic       exp_i;
        exp_r = {mf, 2'b00};
        exp_i = |(mf & irq_en);
        total++;
        if (reg_rdata !== exp_r || irq !== exp_i) begin
            bad++;
            $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                     tag, reg_rdata, irq, exp_r, exp_i);
        end
    endtask

    task automatic expect_reg(string tag, logic [7:0] v);
        total++;
        if (reg_rdata !== v) begin
            bad++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, reg_rdata, v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tick(); tick();
        chk("R1 reset");
        expect_reg("R1 reset value", 8'h00);
        rst = 0;
        tick();

        // R4: ninth edge without tx-empty does nothing
        scl_ninth_rise = 1; tick(); quiet();
        expect_reg("R4 gated off", 8'h00); chk("R4");

        // R3 / R2: tx-empty at bit 7
        ev_tx_empty = 1; tick(); quiet();
        expect_reg("R3 txe bit7", 8'h80); chk("R2");

        // R4: now the ninth edge sets tx-end
        scl_ninth_rise = 1; tick(); quiet();
        expect_reg("R4 tend", 8'hC0); chk("R4");

        // R5: nack gated by enable
        ev_nack = 1; ack_chk_en = 0; tick(); quiet();
        expect_reg("R5 nack off", 8'hC0);
        ev_nack = 1; ack_chk_en = 1; tick(); quiet();
        expect_reg("R5 nack on", 8'hD0); chk("R5");

        // R3: stop and arbitration bits
        ev_stop = 1; ev_arb_lost = 1; ev_rx_full = 1; tick(); quiet();
        expect_reg("R3 all set", 8'hFC); chk("R3");

        // R7: write 0 without read keeps flags
        reg_wr = 1; reg_wdata = 8'h00; tick(); quiet();
        expect_reg("R7 unarmed write", 8'hFC);

        // R8: read then write ones (including low bits)
        reg_rd = 1; tick(); quiet();
        reg_wr = 1; reg_wdata = 8'hFF; tick(); quiet();
        expect_reg("R8 write ones", 8'hFC); chk("R8");

        // R7: the previous write disarmed, so write 0 now does nothing
        reg_wr = 1; reg_wdata = 8'h00; tick(); quiet();
        expect_reg("R7 disarmed", 8'hFC);

        // R6: read then selective clear of bits 7 and 3
        reg_rd = 1; tick(); quiet();
        reg_wr = 1; reg_wdata = 8'h77; tick(); quiet();
        expect_reg("R6 selective clear", 8'h74); chk("R6");

        // R9: rx-full armed and re-set in the clearing cycle
        reg_rd = 1; tick(); quiet();
        reg_wr = 1; reg_wdata = 8'h00; ev_rx_full = 1; tick(); quiet();
        expect_reg("R9 set wins", 8'h20); chk("R9");

        // R10: interrupt masking
        irq_en = 6'b001000; tick(); chk("R10 enabled");
        total++;
        if (irq !== 1'b1) begin bad++; $display("FAIL R10: irq=%0b expected=1", irq); end
        irq_en = 6'b110111; tick(); chk("R10 masked");
        total++;
        if (irq !== 1'b0) begin bad++; $display("FAIL R10: irq=%0b expected=0", irq); end

        // random mix, every cycle checked against the model
        for (int i = 0; i < N_RAND; i++) begin
            ev_tx_empty    = ($urandom % 5) == 0;
            ev_rx_full     = ($urandom % 5) == 0;
            ev_nack        = ($urandom % 5) == 0;
            ev_stop        = ($urandom % 6) == 0;
            ev_arb_lost    = ($urandom % 7) == 0;
            scl_ninth_rise = ($urandom % 3) == 0;
            ack_chk_en     = $urandom % 2;
            reg_rd         = ($urandom % 3) == 0;
            reg_wr         = ($urandom % 4) == 0;
            reg_wdata      = 8'($urandom);
            if ((i % 64) == 0) irq_en = 6'($urandom);
            tick();
            chk("R6 random");
        end
        quiet();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule